// File: doc/BRIEF.md
# Nibble-Carry Arithmetic and Logic Unit

This block is the arithmetic and logic datapath of a small 16-bit processor. Each valid cycle it takes an operation code, a destination operand and a second operand. The second operand can come from a register or a constant. It produces a registered result and updates an internal flag register. Flag updates use a per-flag write mask, so each operation changes only the flags it owns.

Besides the usual carry, the adder reports the carry (or, for subtraction, the borrow) at every quarter boundary of the word. At the default width these are the boundaries after bits 3, 7 and 11. Shifts pass through the carry flag held in the block, so a chain of shifts can move bits between words.

Operand selection, memory access and branching belong to neighbouring blocks.

Top module: `nca_alu`

## Requirements
- R1: After a synchronous reset, `res_q`, `flags_q`, `flag_we_q` and `res_vld_q` are all zero.
- R2: Add (op 0) and increment (op 1) give `dst_val + operand` modulo 2^W. The operand is `src_val` for add and the constant 1 for increment, and `src_val` has no effect on increment. The flag bit positions are: bit 0 C (carry out of the MSB), bit 1 QC, bit 2 HC and bit 3 TC (carries out of bits W/4-1, W/2-1 and 3W/4-1), bit 4 Z (result zero), bit 5 N (result MSB) and bit 6 O (signed overflow). All seven flags are written.
- R3: Subtract (op 2) and decrement (op 3) give `dst_val - operand` modulo 2^W, with decrement using the constant 1. C, QC, HC and TC are the borrows out of the same bit positions as in R2. Z, N and O are defined as in R2, with O being signed overflow of the difference. All seven flags are written.
- R4: AND (op 4), OR (op 5), XOR (op 6) and NOT of `dst_val` (op 7) write only Z (bit 4).
- R5: Shift left (op 8) gives `{dst[W-2:0], C}` and sets C to the old `dst[W-1]`. Shift right (op 9) gives `{C, dst[W-1:1]}` and sets C to the old `dst[0]`. Both write only C and Z.
- R6: Rotate left (op 10) and rotate right (op 11) wrap the end bit around to the other end and write no flag.
- R7: Swap (op 12) exchanges the upper and lower halves of `dst_val` and writes no flag.
- R8: When `op_valid` is low, `res_q` and `flags_q` hold, and `res_vld_q` and `flag_we_q` are zero on the next cycle.
- R9: Op codes 13 to 15 give `res_q = dst_val` and write no flag.
- R10: `flag_we_q` shows the write mask of the operation registered in that cycle. A flag whose mask bit is clear keeps its value.
- R11: A shift uses the carry written by the operation in the immediately preceding cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code |
| dst_val | input | W | Destination operand |
| src_val | input | W | Second operand (register or constant) |
| res_q | output | W | Registered result |
| res_vld_q | output | 1 | Result registered this cycle |
| flag_we_q | output | 7 | Flag write mask of the last operation |
| flags_q | output | 7 | Flag register {O,N,Z,TC,HC,QC,C} |

## Verification
Two functions can land in the same cycle. A shift reads the carry flag while the flag register is still taking the carry written by the operation just before it. The bench provokes this by issuing operations back to back with no idle cycles. It runs whole sweeps of shifts and rotates where each one depends on the carry left by its predecessor, and it places an add that overflows directly ahead of a shift. Every result is judged against a flag state that the bench carries forward by its own arithmetic. A carry that is stale or written too late therefore shows up both in the shifted-in bit and in the next C flag.

// File: rtl/nca_pkg.sv
package nca_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_INC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_DEC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOT  = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROR  = 4'd11,
    OP_SWAP = 4'd12
  } nca_op_e;

  localparam int NFLAG = 7;
  localparam int FL_C  = 0;
  localparam int FL_QC = 1;
  localparam int FL_HC = 2;
  localparam int FL_TC = 3;
  localparam int FL_Z  = 4;
  localparam int FL_N  = 5;
  localparam int FL_O  = 6;

  localparam logic [NFLAG-1:0] FM_ALL  = 7'b111_1111;
  localparam logic [NFLAG-1:0] FM_Z    = 7'b001_0000;
  localparam logic [NFLAG-1:0] FM_CZ   = 7'b001_0001;
  localparam logic [NFLAG-1:0] FM_NONE = 7'b000_0000;

endpackage

// File: rtl/nca_arith.sv
module nca_arith #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic [3:0]   seg_cy,
  output logic         ovf
);
  localparam int Q = W / 4;

  logic [W-1:0] b_eff;
  logic [4:0]   cy;

  assign b_eff = sub ? ~b : b;
  assign cy[0] = sub;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_seg
      logic [Q:0] part;
      assign part = {1'b0, a[g*Q +: Q]} + {1'b0, b_eff[g*Q +: Q]} + {{Q{1'b0}}, cy[g]};
      assign sum[g*Q +: Q] = part[Q-1:0];
      assign cy[g+1]       = part[Q];
      // borrow is the inverted carry when subtracting
      assign seg_cy[g]     = cy[g+1] ^ sub;
    end
  endgenerate

  assign ovf = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);

endmodule

// File: rtl/nca_logic.sv
module nca_logic
  import nca_pkg::*;
#(
  parameter int W = 16
) (
  input  nca_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int H = W / 2;

  always_comb begin
    cout = cin;
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_SHL: begin
        res  = {a[W-2:0], cin};
        cout = a[W-1];
      end
      OP_SHR: begin
        res  = {cin, a[W-1:1]};
        cout = a[0];
      end
      OP_ROL:  res = {a[W-2:0], a[W-1]};
      OP_ROR:  res = {a[0], a[W-1:1]};
      OP_SWAP: res = {a[H-1:0], a[W-1:H]};
      default: res = a;
    endcase
  end

endmodule

// File: rtl/nca_flagreg.sv
module nca_flagreg #(
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] wr,
  input  logic [NF-1:0] nxt,
  output logic [NF-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~wr) | (nxt & wr);
  end

  genvar i;
  generate
    for (i = 0; i < NF; i++) begin : g_chk
      AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (rst)
        !wr[i] |=> $stable(q[i])); // R10
    end
  endgenerate

endmodule

// File: rtl/nca_alu.sv
module nca_alu
  import nca_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [3:0]       op_sel,
  input  logic [W-1:0]     dst_val,
  input  logic [W-1:0]     src_val,
  output logic [W-1:0]     res_q,
  output logic             res_vld_q,
  output logic [NFLAG-1:0] flag_we_q,
  output logic [NFLAG-1:0] flags_q
);

  nca_op_e          op;
  logic             is_arith;
  logic             is_sub;
  logic [W-1:0]     operand;
  logic [NFLAG-1:0] mask;
  logic [NFLAG-1:0] wr;
  logic [NFLAG-1:0] nf;
  logic [W-1:0]     a_sum;
  logic [3:0]       a_cy;
  logic             a_ovf;
  logic [W-1:0]     l_res;
  logic             l_cout;
  logic [W-1:0]     res;

  assign op = nca_op_e'(op_sel);

  always_comb begin
    is_arith = 1'b0;
    is_sub   = 1'b0;
    operand  = src_val;
    unique case (op)
      OP_ADD: begin is_arith = 1'b1; mask = FM_ALL; end
      OP_INC: begin is_arith = 1'b1; operand = W'(1); mask = FM_ALL; end
      OP_SUB: begin is_arith = 1'b1; is_sub = 1'b1; mask = FM_ALL; end
      OP_DEC: begin is_arith = 1'b1; is_sub = 1'b1; operand = W'(1); mask = FM_ALL; end
      OP_AND, OP_OR, OP_XOR, OP_NOT: mask = FM_Z;
      OP_SHL, OP_SHR:                mask = FM_CZ;
      default:                       mask = FM_NONE;
    endcase
  end

  nca_arith #(.W(W)) u_arith (
    .a      (dst_val),
    .b      (operand),
    .sub    (is_sub),
    .sum    (a_sum),
    .seg_cy (a_cy),
    .ovf    (a_ovf)
  );

  nca_logic #(.W(W)) u_logic (
    .op   (op),
    .a    (dst_val),
    .b    (src_val),
    .cin  (flags_q[FL_C]),
    .res  (l_res),
    .cout (l_cout)
  );

  assign res = is_arith ? a_sum : l_res;

  always_comb begin
    nf        = '0;
    nf[FL_C]  = is_arith ? a_cy[3] : l_cout;
    nf[FL_QC] = a_cy[0];
    nf[FL_HC] = a_cy[1];
    nf[FL_TC] = a_cy[2];
    nf[FL_Z]  = (res == '0);
    nf[FL_N]  = res[W-1];
    nf[FL_O]  = a_ovf;
  end

  assign wr = op_valid ? mask : FM_NONE;

  nca_flagreg #(.NF(NFLAG)) u_flags (
    .clk (clk),
    .rst (rst),
    .wr  (wr),
    .nxt (nf),
    .q   (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= '0;
      res_vld_q <= 1'b0;
      flag_we_q <= '0;
    end else begin
      res_vld_q <= op_valid;
      flag_we_q <= wr;
      if (op_valid) res_q <= res;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(res_q) && $stable(flags_q) && !res_vld_q); // R8
  AST_ARITH_N: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_sel <= 4'd3 |=> flags_q[FL_N] == res_q[W-1]); // R2
  AST_LOGIC_Z_ONLY: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_sel >= 4'd4 && op_sel <= 4'd7
    |=> $stable(flags_q[3:0]) && $stable(flags_q[6:5])); // R4
  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_sel == 4'd8 |=> flags_q[FL_C] == $past(dst_val[W-1])); // R5
  AST_SHL_FEED: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_sel == 4'd8 |=> res_q[0] == $past(flags_q[FL_C])); // R11
  AST_ROT_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_sel >= 4'd10 && op_sel <= 4'd12 |=> $stable(flags_q)); // R6
  AST_UNDEF_PASS: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_sel > 4'd12 |=> $stable(flags_q) && res_q == $past(dst_val)); // R9

endmodule

// File: tb/nca_alu_bench.sv
module nca_alu_bench;
  localparam int BW = 8;
  localparam int BQ = BW / 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [3:0]    op_sel = '0;
  logic [BW-1:0] dst_val = '0;
  logic [BW-1:0] src_val = '0;
  logic [BW-1:0] res_q;
  logic          res_vld_q;
  logic [6:0]    flag_we_q;
  logic [6:0]    flags_q;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic [6:0] exp_flags = '0;

  always #5 clk = ~clk;

  nca_alu #(.W(BW)) u_nca_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .dst_val(dst_val), .src_val(src_val), .res_q(res_q),
    .res_vld_q(res_vld_q), .flag_we_q(flag_we_q), .flags_q(flags_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    if (op <= 1)  return "R2";
    if (op <= 3)  return "R3";
    if (op <= 7)  return "R4";
    if (op <= 9)  return "R5 R11";
    if (op <= 11) return "R6";
    if (op == 12) return "R7";
    return "R9";
  endfunction

  task automatic model(input int op, input int d, input int s0, input bit cin,
                       output logic [BW-1:0] r, output logic [6:0] f, output logic [6:0] m);
    int lim = 1 << BW;
    int s = s0;
    int v, sd, ss, sv;
    f = '0;
    m = '0;
    if (op == 1 || op == 3) s = 1;
    if (op <= 3) begin
      sd = (d >= lim/2) ? d - lim : d;
      ss = (s >= lim/2) ? s - lim : s;
      if (op <= 1) begin
        v = d + s; sv = sd + ss;
        f[0] = (v >= lim);
        for (int k = 1; k <= 3; k++) begin
          int mk = (1 << (k*BQ)) - 1;
          f[k] = ((d & mk) + (s & mk)) >= (mk + 1);
        end
      end else begin
        v = d - s + lim; sv = sd - ss;
        f[0] = (d < s);
        for (int k = 1; k <= 3; k++) begin
          int mk = (1 << (k*BQ)) - 1;
          f[k] = (d & mk) < (s & mk);
        end
      end
      r = BW'(v);
      f[6] = (sv >= lim/2) || (sv < -(lim/2));
      m = 7'h7F;
    end else begin
      case (op)
        4: begin r = BW'(d & s); m = 7'h10; end
        5: begin r = BW'(d | s); m = 7'h10; end
        6: begin r = BW'(d ^ s); m = 7'h10; end
        7: begin r = BW'(~d);    m = 7'h10; end
        8: begin r = BW'((d << 1) | int'(cin)); f[0] = d[BW-1]; m = 7'h11; end
        9: begin r = BW'((d >> 1) | (int'(cin) << (BW-1))); f[0] = d[0]; m = 7'h11; end
        10: r = BW'((d << 1) | (d >> (BW-1)));
        11: r = BW'((d >> 1) | ((d & 1) << (BW-1)));
        12: r = BW'(((d & ((1 << (BW/2)) - 1)) << (BW/2)) | (d >> (BW/2)));
        default: r = BW'(d);
      endcase
    end
    f[4] = (r == 0);
    f[5] = r[BW-1];
  endtask

  // called at a falling edge; result is checked at the next falling edge
  task automatic run(input int op, input int d, input int s);
    logic [BW-1:0] r;
    logic [6:0] f, m;
    model(op, d, s, exp_flags[0], r, f, m);
    exp_flags = (exp_flags & ~m) | (f & m);
    op_valid = 1'b1; op_sel = 4'(op); dst_val = BW'(d); src_val = BW'(s);
    @(negedge clk);
    chk({tag_of(op), " result"}, int'(res_q), int'(r));
    chk({tag_of(op), " flags"}, int'(flags_q), int'(exp_flags));
    chk("R10 write mask", int'(flag_we_q), int'(m));
    chk("R8 valid out", int'(res_vld_q), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 result", int'(res_q), 0);
    chk("R1 flags", int'(flags_q), 0);
    chk("R1 mask", int'(flag_we_q), 0);
    chk("R1 valid", int'(res_vld_q), 0);

    for (int op = 0; op <= 2; op += 2)
      for (int d = 0; d < (1 << BW); d++)
        for (int s = 0; s < (1 << BW); s += 3) run(op, d, s);
    for (int d = 0; d < (1 << BW); d++) run(1, d, d ^ 8'h5A);
    for (int d = 0; d < (1 << BW); d++) run(3, d, ~d);
    for (int op = 4; op <= 7; op++)
      for (int d = 0; d < (1 << BW); d++)
        for (int s = 0; s < (1 << BW); s += 7) run(op, d, s);
    for (int op = 8; op <= 12; op++)
      for (int d = 0; d < (1 << BW); d++) run(op, d, 0);

    // R11: carry from an overflowing add feeds the very next shift
    run(0, 8'hFF, 8'h01);
    run(8, 8'h00, 0);
    chk("R11 carry shifted in", int'(res_q[0]), 1);
    run(2, 8'h00, 8'h01);
    run(9, 8'h02, 0);
    chk("R11 borrow shifted in", int'(res_q[BW-1]), 1);

    // R9: undefined codes
    for (int op = 13; op <= 15; op++) run(op, 8'hA5 ^ op, 8'h3C);

    // R8: idle cycle with changing inputs
    begin
      logic [BW-1:0] keep_r;
      logic [6:0]    keep_f;
      keep_r = res_q; keep_f = flags_q;
      op_valid = 1'b0; op_sel = 4'd0; dst_val = 8'hFF; src_val = 8'hFF;
      @(negedge clk);
      chk("R8 result held", int'(res_q), int'(keep_r));
      chk("R8 flags held", int'(flags_q), int'(keep_f));
      chk("R8 mask zero", int'(flag_we_q), 0);
      chk("R8 valid low", int'(res_vld_q), 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule